// File: doc/BRIEF.md
# Parallel Host Port Slave

This block lets an external host processor exchange bytes with an on-chip core over an asynchronous parallel bus. The host has an active-low select, separate active-low read and write strobes, a 4-bit address and an 8-bit data path. The data path is split into an input byte, an output byte and an output enable for the pad. Every host pin is resampled into the core clock through a two-stage synchronizer. A host cycle takes effect on its trailing edge, which is the moment the select or the strobe returns high. A cycle is only counted if the strobe stayed active long enough.

Bytes written to the data port travel through a small input queue to the core, which takes them over a valid/ready stream. Each accepted byte raises a busy indication a fixed number of core clocks later. Busy stays up for as long as the input queue is full, so the host has to wait for busy to go high again before it sends the next byte. A write that arrives while busy is shown is discarded and leaves a sticky overflow mark. The core sends bytes back through an outgoing queue. Putting a byte into an empty outgoing queue pulls the interrupt line low, and the line is released by the host read that takes the last byte. Fourteen further addresses act as plain byte registers, and one address reads back a status byte.

Top module: `host_port_slave`

## Requirements
- R1: While reset is held and right after it, hp_busy_n and hp_irq_n are high, hp_rdata_oe is low, rx_valid is low and tx_full is low.
- R2: hp_rdata_oe is high only while both hp_sel_n and hp_rd_n are low. It drops without any clock as soon as either of them rises, and it stays low during writes.
- R3: A byte written to address 0 appears on rx_data/rx_valid, in write order. While rx_valid is high and rx_ready is low, rx_valid and rx_data hold.
- R4: After an accepted write to address 0, hp_busy_n goes low at the fifth rising clock edge after the trailing edge of the write. That count is two synchronizer stages, one edge-detect register and a two-clock lag. If the input queue has room, hp_busy_n returns high at the next rising edge.
- R5: While the 4-entry input queue is full, hp_busy_n stays low. It returns high at the rising edge that follows the first core pop.
- R6: A write to address 0 while hp_busy_n is low is dropped and sets the overflow bit. The bit stays set until the host reads address 1, and it clears at the trailing edge of that read.
- R7: Addresses 2 to 15 are independent byte registers. Each reads back the last value written to it, and all of them reset to 0.
- R8: Reading address 1 returns the status byte: bit 0 is busy, bit 1 is overflow, bit 2 is interrupt pending, and bits 7:3 are zero. Writes to address 1 change nothing.
- R9: A core push into an empty outgoing queue drives hp_irq_n low at that clock edge. Reads of address 0 return the queued bytes in push order, and hp_irq_n goes high at the trailing edge of the read that empties the queue.
- R10: A strobe seen low for fewer than 2 synchronized clocks is ignored. A strobe seen low for exactly 2 clocks is accepted.
- R11: A cycle is accepted whether the select or the strobe falls first.
- R12: Reading address 0 while the outgoing queue is empty returns 0 and has no effect. tx_full is high when 4 bytes are queued, and a push in that state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_sel_n | input | 1 | Host select, active low |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_wr_n | input | 1 | Host write strobe, active low |
| hp_addr | input | 4 | Host byte address |
| hp_wdata | input | 8 | Data from the host |
| hp_rdata | output | 8 | Data to the host |
| hp_rdata_oe | output | 1 | Pad output enable for hp_rdata |
| hp_busy_n | output | 1 | Busy handshake, active low |
| hp_irq_n | output | 1 | Interrupt to the host, active low |
| rx_data | output | 8 | Received byte to the core |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Core accepts the received byte |
| tx_data | input | 8 | Byte from the core for the host |
| tx_push | input | 1 | Enqueue tx_data |
| tx_full | output | 1 | Outgoing queue full |

## Verification
Suppose the input queue count or the busy lag is wrong. hp_busy_n then falls on the wrong edge or never releases, and the bench detects this within six clocks of a write by counting edges from the trailing edge. A wrong overflow or interrupt register shows up in the status byte at the next host read of address 1. A wrong outgoing queue pointer shows up on hp_irq_n, or as out-of-order bytes in the next read of address 0. Register file corruption, or a strobe-width filter that accepts glitches, is caught by the read-back that follows each write.

// File: rtl/hps_pkg.sv
package hps_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    // address roles; the general registers follow the two fixed ports
    localparam addr_t ADDR_FIFO = addr_t'(0);
    localparam addr_t ADDR_STAT = addr_t'(1);
    localparam int    REG_BASE  = 2;
    localparam int    NUM_REGS  = (1 << ADDR_W) - REG_BASE;

    // status byte bit positions
    localparam int STAT_BUSY = 0;
    localparam int STAT_OVF  = 1;
    localparam int STAT_IRQ  = 2;

    // strobe kinds, indexes of the strobe detector array
    localparam int KIND_RD = 0;
    localparam int KIND_WR = 1;
    localparam int NUM_KINDS = 2;

    typedef struct packed {
        logic  sel_n;
        logic  rd_n;
        logic  wr_n;
        addr_t addr;
        byte_t data;
    } host_pins_t;

    typedef struct packed {
        logic  fire;
        addr_t addr;
    } host_cyc_t;

    localparam host_pins_t PINS_IDLE = '{sel_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                         addr: '0, data: '0};

    function automatic byte_t pack_status(input logic busy, input logic ovf,
                                          input logic irq);
        byte_t s;
        s = '0;
        s[STAT_BUSY] = busy;
        s[STAT_OVF]  = ovf;
        s[STAT_IRQ]  = irq;
        return s;
    endfunction

endpackage

// File: rtl/hps_sync.sv
// Two-stage resynchronizer for a bundle of host pins.
module hps_sync #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= INIT;
            q      <= INIT;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/hps_strobe.sv
// Trailing-edge detector with a minimum-active-width filter.
module hps_strobe
    import hps_pkg::*;
#(
    parameter int MIN_ACTIVE = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  addr_t     addr,
    output host_cyc_t cyc
);
    localparam int CW = $clog2(MIN_ACTIVE + 1);

    logic          act_q;
    logic [CW-1:0] width_q;
    addr_t         addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            width_q <= '0;
            addr_q  <= '0;
        end else begin
            act_q <= active;
            if (active) begin
                addr_q <= addr;
                if (width_q != CW'(MIN_ACTIVE))
                    width_q <= width_q + 1'b1;
            end else begin
                width_q <= '0;
            end
        end
    end

    assign cyc.fire = act_q && !active && (width_q == CW'(MIN_ACTIVE));
    assign cyc.addr = addr_q;
endmodule

// File: rtl/hps_fifo.sv
// Small circular byte queue reporting its fill count.
module hps_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    assign dout = mem[rp_q];
endmodule

// File: rtl/host_port_slave.sv
module host_port_slave
    import hps_pkg::*;
#(
    parameter int RX_DEPTH   = 4,
    parameter int TX_DEPTH   = 4,
    parameter int MIN_ACTIVE = 2,
    parameter int BUSY_LAG   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hp_sel_n,
    input  logic        hp_rd_n,
    input  logic        hp_wr_n,
    input  logic [3:0]  hp_addr,
    input  logic [7:0]  hp_wdata,
    output logic [7:0]  hp_rdata,
    output logic        hp_rdata_oe,
    output logic        hp_busy_n,
    output logic        hp_irq_n,
    output logic [7:0]  rx_data,
    output logic        rx_valid,
    input  logic        rx_ready,
    input  logic [7:0]  tx_data,
    input  logic        tx_push,
    output logic        tx_full
);
    localparam int RXCW = $clog2(RX_DEPTH + 1);
    localparam int TXCW = $clog2(TX_DEPTH + 1);
    localparam int LAGW = $clog2(BUSY_LAG + 1);

    // ---------------- state and nets ----------------
    host_pins_t        pins_raw, pins_syn;
    logic [NUM_KINDS-1:0] strb_act;
    host_cyc_t         strb_cyc [NUM_KINDS];
    host_cyc_t         rd_cyc, wr_cyc;
    byte_t             wr_data_q;

    logic              busy_q, ovf_q, irq_q;
    logic [LAGW-1:0]   lag_q;

    logic [RXCW-1:0]   rx_cnt;
    logic [TXCW-1:0]   tx_cnt;
    byte_t             tx_head;
    logic              rx_full, tx_empty, tx_push_ok;
    logic              wr_fifo_ev, rx_push, wr_drop, stat_rd, tx_pop;

    byte_t             regs [NUM_REGS];
    logic [NUM_REGS-1:0] reg_we;
    addr_t             reg_idx;

    // ---------------- synchronizer ----------------
    assign pins_raw = '{sel_n: hp_sel_n, rd_n: hp_rd_n, wr_n: hp_wr_n,
                        addr: hp_addr, data: hp_wdata};

    hps_sync #(
        .W    ($bits(host_pins_t)),
        .INIT (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_syn)
    );

    // ---------------- strobe detectors ----------------
    assign strb_act[KIND_RD] = !pins_syn.sel_n && !pins_syn.rd_n;
    assign strb_act[KIND_WR] = !pins_syn.sel_n && !pins_syn.wr_n;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_strobe
        hps_strobe #(
            .MIN_ACTIVE (MIN_ACTIVE)
        ) u_strobe (
            .clk    (clk),
            .rst    (rst),
            .active (strb_act[k]),
            .addr   (pins_syn.addr),
            .cyc    (strb_cyc[k])
        );
    end

    assign rd_cyc = strb_cyc[KIND_RD];
    assign wr_cyc = strb_cyc[KIND_WR];

    always_ff @(posedge clk) begin
        if (rst)                    wr_data_q <= '0;
        else if (strb_act[KIND_WR]) wr_data_q <= pins_syn.data;
    end

    // ---------------- cycle decode ----------------
    assign rx_full    = (rx_cnt == RXCW'(RX_DEPTH));
    assign tx_empty   = (tx_cnt == '0);
    assign tx_full    = (tx_cnt == TXCW'(TX_DEPTH));
    assign tx_push_ok = tx_push && !tx_full;

    assign wr_fifo_ev = wr_cyc.fire && (wr_cyc.addr == ADDR_FIFO);
    assign rx_push    = wr_fifo_ev && !busy_q && !rx_full;
    assign wr_drop    = wr_fifo_ev && !rx_push;
    assign stat_rd    = rd_cyc.fire && (rd_cyc.addr == ADDR_STAT);
    assign tx_pop     = rd_cyc.fire && (rd_cyc.addr == ADDR_FIFO) && !tx_empty;

    // ---------------- queues ----------------
    hps_fifo #(
        .DEPTH (RX_DEPTH),
        .W     (DATA_W)
    ) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (wr_data_q),
        .pop   (rx_valid && rx_ready),
        .dout  (rx_data),
        .count (rx_cnt)
    );

    assign rx_valid = (rx_cnt != '0);

    hps_fifo #(
        .DEPTH (TX_DEPTH),
        .W     (DATA_W)
    ) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push_ok),
        .din   (tx_data),
        .pop   (tx_pop),
        .dout  (tx_head),
        .count (tx_cnt)
    );

    // ---------------- handshake, overflow, interrupt ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            lag_q  <= '0;
            busy_q <= 1'b0;
            ovf_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (rx_push)            lag_q <= LAGW'(BUSY_LAG);
            else if (lag_q != '0)   lag_q <= lag_q - 1'b1;

            if (lag_q == LAGW'(1) && !rx_push) busy_q <= 1'b1;
            else if (busy_q && !rx_full)       busy_q <= 1'b0;

            if (wr_drop)      ovf_q <= 1'b1;
            else if (stat_rd) ovf_q <= 1'b0;

            if (tx_push_ok && tx_empty)
                irq_q <= 1'b1;
            else if (tx_pop && tx_cnt == TXCW'(1) && !tx_push_ok)
                irq_q <= 1'b0;
        end
    end

    assign hp_busy_n = !busy_q;
    assign hp_irq_n  = !irq_q;

    // ---------------- general registers ----------------
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg_we
        assign reg_we[i] = wr_cyc.fire && (wr_cyc.addr == addr_t'(i + REG_BASE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++)
                if (reg_we[i]) regs[i] <= wr_data_q;
        end
    end

    // ---------------- host read path ----------------
    assign hp_rdata_oe = !hp_sel_n && !hp_rd_n;
    assign reg_idx     = hp_addr - addr_t'(REG_BASE);

    always_comb begin
        if (hp_addr == ADDR_FIFO)
            hp_rdata = tx_empty ? '0 : tx_head;
        else if (hp_addr == ADDR_STAT)
            hp_rdata = pack_status(busy_q, ovf_q, irq_q);
        else
            hp_rdata = regs[reg_idx];
    end
endmodule

// File: rtl/host_port_slave_chk.sv
module host_port_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       hp_busy_n,
    input logic       hp_irq_n,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       rx_push,
    input logic       wr_fifo_ev,
    input logic       ovf_q,
    input logic       stat_rd,
    input logic       tx_empty
);
    // tap of 3 matches the default two-clock busy lag plus one sampling edge
    assert_busy_lag_R4: assert property (@(posedge clk) disable iff (rst)
        $past(rx_push, 3) |-> !hp_busy_n);

    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_fifo_ev && !hp_busy_n) |-> !rx_push);

    assert_rx_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(ovf_q) && !$past(stat_rd)) |-> ovf_q);

    assert_irq_tracks_queue_R9: assert property (@(posedge clk) disable iff (rst)
        hp_irq_n == tx_empty);
endmodule

bind host_port_slave host_port_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hp_busy_n  (hp_busy_n),
    .hp_irq_n   (hp_irq_n),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .rx_push    (rx_push),
    .wr_fifo_ev (wr_fifo_ev),
    .ovf_q      (ovf_q),
    .stat_rd    (stat_rd),
    .tx_empty   (tx_empty)
);

// File: tb/host_port_slave_bench.sv
module host_port_slave_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hp_sel_n = 1'b1, hp_rd_n = 1'b1, hp_wr_n = 1'b1;
    logic [3:0] hp_addr = '0;
    logic [7:0] hp_wdata = '0;
    logic [7:0] hp_rdata;
    logic       hp_rdata_oe, hp_busy_n, hp_irq_n;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_push = 1'b0;
    logic       tx_full;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [16];
    logic [7:0] got [$];
    logic [7:0] exp_rx [$];

    always #2 clk = ~clk;

    host_port_slave u_host_port_slave (
        .clk (clk), .rst (rst),
        .hp_sel_n (hp_sel_n), .hp_rd_n (hp_rd_n), .hp_wr_n (hp_wr_n),
        .hp_addr (hp_addr), .hp_wdata (hp_wdata),
        .hp_rdata (hp_rdata), .hp_rdata_oe (hp_rdata_oe),
        .hp_busy_n (hp_busy_n), .hp_irq_n (hp_irq_n),
        .rx_data (rx_data), .rx_valid (rx_valid), .rx_ready (rx_ready),
        .tx_data (tx_data), .tx_push (tx_push), .tx_full (tx_full)
    );

    always @(posedge clk) begin
        if (!rst && rx_valid && rx_ready) got.push_back(rx_data);
    end

    function automatic logic [7:0] status_exp(input logic busy, input logic ovf,
                                              input logic irq);
        return {5'b0, irq, ovf, busy};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] d,
                              input int low, input bit strobe_first);
        @(negedge clk);
        hp_addr = a; hp_wdata = d;
        if (strobe_first) begin
            hp_wr_n = 1'b0; tick(1); hp_sel_n = 1'b0;
        end else begin
            hp_sel_n = 1'b0; hp_wr_n = 1'b0;
        end
        tick(low);
        chk("R2 no drive in write", int'(hp_rdata_oe), 0);
        hp_wr_n = 1'b1; hp_sel_n = 1'b1;
        tick(6);
    endtask

    task automatic host_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        hp_addr = a; hp_sel_n = 1'b0; hp_rd_n = 1'b0;
        tick(4);
        d = hp_rdata;
        chk("R2 drive during read", int'(hp_rdata_oe), 1);
        hp_rd_n = 1'b1; hp_sel_n = 1'b1;
        #1;
        chk("R2 release after read", int'(hp_rdata_oe), 0);
        tick(6);
    endtask

    task automatic compare_rx(input string req);
        chk({req, " count"}, got.size(), exp_rx.size());
        for (int i = 0; i < exp_rx.size() && i < got.size(); i++)
            chk({req, " byte"}, int'(got[i]), int'(exp_rx[i]));
        got.delete();
        exp_rx.delete();
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;

        // R1 reset state
        tick(4);
        chk("R1 busy in reset", int'(hp_busy_n), 1);
        chk("R1 irq in reset", int'(hp_irq_n), 1);
        chk("R1 oe in reset", int'(hp_rdata_oe), 0);
        rst = 1'b0;
        tick(2);
        chk("R1 busy after reset", int'(hp_busy_n), 1);
        chk("R1 irq after reset", int'(hp_irq_n), 1);
        chk("R1 rx_valid after reset", int'(rx_valid), 0);
        chk("R1 tx_full after reset", int'(tx_full), 0);
        host_read(4'd9, rd);
        chk("R7 register resets to 0", int'(rd), 0);

        // R7 random register traffic
        for (int i = 0; i < 20; i++) begin
            logic [3:0] a;
            logic [7:0] d;
            a = 4'(2 + $urandom_range(0, 13));
            d = 8'($urandom);
            host_write(a, d, 4, 1'b0);
            model[a] = d;
            a = 4'(2 + $urandom_range(0, 13));
            host_read(a, rd);
            chk("R7 register read-back", int'(rd), int'(model[a]));
        end

        // R11 strobe falls before select
        host_write(4'd5, 8'hA5, 4, 1'b1);
        model[5] = 8'hA5;
        host_read(4'd5, rd);
        chk("R11 strobe-first write", int'(rd), 8'hA5);

        // R10 width filter: one clock ignored, two accepted
        host_write(4'd3, 8'h3C, 1, 1'b0);
        host_read(4'd3, rd);
        chk("R10 short strobe ignored", int'(rd), int'(model[3]));
        host_write(4'd3, 8'hC3, 2, 1'b0);
        model[3] = 8'hC3;
        host_read(4'd3, rd);
        chk("R10 minimum strobe accepted", int'(rd), 8'hC3);

        // R8 status writes ignored
        host_write(4'd1, 8'hFF, 4, 1'b0);
        host_read(4'd1, rd);
        chk("R8 status after write", int'(rd), int'(status_exp(1'b0, 1'b0, 1'b0)));

        // R3 stream order
        rx_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            host_write(4'd0, d, 4, 1'b0);
            exp_rx.push_back(d);
        end
        tick(4);
        compare_rx("R3 stream");

        // R4 busy lag, counted from the trailing edge
        @(negedge clk);
        hp_addr = 4'd0; hp_wdata = 8'h5A; hp_sel_n = 1'b0; hp_wr_n = 1'b0;
        tick(4);
        hp_wr_n = 1'b1; hp_sel_n = 1'b1;
        exp_rx.push_back(8'h5A);
        tick(4);
        chk("R4 busy not yet", int'(hp_busy_n), 1);
        tick(1);
        chk("R4 busy on fifth edge", int'(hp_busy_n), 0);
        tick(1);
        chk("R4 busy released with room", int'(hp_busy_n), 1);
        tick(4);
        compare_rx("R4 stream");

        // R5 / R6 fill, overflow, drain
        @(negedge clk);
        rx_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            host_write(4'd0, d, 4, 1'b0);
            exp_rx.push_back(d);
        end
        chk("R5 busy while full", int'(hp_busy_n), 0);
        tick(10);
        chk("R5 busy held while full", int'(hp_busy_n), 0);
        host_write(4'd0, 8'hEE, 4, 1'b0);
        host_read(4'd1, rd);
        chk("R6 status shows overflow", int'(rd), int'(status_exp(1'b1, 1'b1, 1'b0)));
        host_read(4'd1, rd);
        chk("R6 overflow cleared by status read", int'(rd),
            int'(status_exp(1'b1, 1'b0, 1'b0)));
        @(negedge clk);
        rx_ready = 1'b1;
        tick(1);
        chk("R5 busy kept at pop edge", int'(hp_busy_n), 0);
        tick(1);
        chk("R5 busy released after pop", int'(hp_busy_n), 1);
        tick(6);
        compare_rx("R6 dropped byte absent");

        // R12 empty read; R9 interrupt and order
        host_read(4'd0, rd);
        chk("R12 empty queue reads 0", int'(rd), 0);
        chk("R12 irq unaffected", int'(hp_irq_n), 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            tx_data = 8'h10 + 8'(i); tx_push = 1'b1;
            tick(1);
            tx_push = 1'b0;
            if (i == 0) chk("R9 irq on push into empty", int'(hp_irq_n), 0);
            if (i == 3) chk("R12 tx_full at four", int'(tx_full), 1);
        end
        for (int i = 0; i < 4; i++) begin
            host_read(4'd0, rd);
            chk("R9 outgoing order", int'(rd), 8'h10 + i);
            chk("R9 irq level after read", int'(hp_irq_n), (i == 3) ? 1 : 0);
        end
        host_read(4'd0, rd);
        chk("R12 push while full ignored", int'(rd), 0);
        host_read(4'd1, rd);
        chk("R8 status idle", int'(rd), int'(status_exp(1'b0, 1'b0, 1'b0)));

        // mixed random traffic (R3, R7)
        for (int i = 0; i < 30; i++) begin
            int op;
            logic [3:0] a;
            logic [7:0] d;
            op = $urandom_range(0, 2);
            a = 4'(2 + $urandom_range(0, 13));
            d = 8'($urandom);
            if (op == 0) begin
                host_write(a, d, 3, 1'($urandom_range(0, 1)));
                model[a] = d;
            end else if (op == 1) begin
                host_read(a, rd);
                chk("R7 mixed read-back", int'(rd), int'(model[a]));
            end else begin
                host_write(4'd0, d, 3, 1'b0);
                exp_rx.push_back(d);
            end
        end
        tick(6);
        compare_rx("R3 mixed stream");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule